// File: doc/BRIEF.md
# Peripheral Access Strobe Timer

This block times a single peripheral access on behalf of one DMA channel. A one-cycle start pulse begins an access. The block then counts a setup phase and drives the acknowledge strobe for a programmable number of cycles. After that it counts a hold phase and gives a one-cycle done pulse to the channel's sequencer. The three phase lengths come from fields of the channel control word, and the block captures them when the access starts.

The block also sits between the internal logic and the channel's handshake pins. It takes three bits from a shared polarity word. The channel index parameter selects which three. Each bit can make the request, acknowledge or end-of-transfer pin active low. The end-of-transfer pin normally carries an incoming request to end the transfer. A control bit can turn it into an output. In that mode, and when terminal-count handling is enabled, the pin signals that the current access is the channel's last one.

Top module: `stb_timer`

## Requirements
- R1: After reset, the block is idle. The acknowledge pin and the end-of-transfer output pin are at their inactive levels, and `done` is 0.
- R2: A start pulse accepted while idle gives S setup cycles with acknowledge inactive, then W+1 cycles with acknowledge active. S is `ctl_word[20:19]` and W is `ctl_word[18:13]`. The first setup cycle is the first cycle after the clock edge that samples start.
- R3: After the acknowledge phase come H hold cycles with acknowledge inactive, where H is `ctl_word[12:10]`. Then `done` is high for exactly one cycle, and the block returns to idle.
- R4: S=0 skips the setup phase and H=0 skips the hold phase, with no filler cycle. With S=W=H=0 the access is one acknowledge cycle followed by one done cycle.
- R5: A start pulse that arrives while an access is in progress, including its done cycle, is ignored.
- R6: The setup, wait, hold, direction, terminal-count-enable and last-access values are captured at the accepted start. Changes to `ctl_word` or `last_xfer` during an access do not affect that access.
- R7: The acknowledge pin is active low when `pol_word[30-3*CH_IDX]` is 1 and active high when it is 0.
- R8: `req_act` is `req_pin` corrected by `pol_word[31-3*CH_IDX]`, where a 1 means the pin is active low.
- R9: When `ctl_word[9]` is 0, `eot_req` is `eot_pin_in` corrected by `pol_word[29-3*CH_IDX]`, where a 1 means active low. When `ctl_word[9]` is 1, `eot_req` is 0.
- R10: `eot_oe` equals `ctl_word[9]`. If the captured `ctl_word[9]`, the captured `ctl_word[8]` and the captured `last_xfer` are all 1, the end-of-transfer output is active exactly during the acknowledge cycles. Its polarity comes from the bit named in R9.
- R11: If the captured `ctl_word[8]` is 0, or the captured `last_xfer` is 0, the end-of-transfer output stays inactive for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an access |
| ctl_word | input | 32 | Channel control word (timing fields, pin direction, terminal-count enable) |
| pol_word | input | 32 | Shared polarity word, three bits per channel |
| last_xfer | input | 1 | The access about to start is the channel's last one |
| req_pin | input | 1 | Raw request pin |
| eot_pin_in | input | 1 | Raw end-of-transfer pin, input direction |
| ack_pin | output | 1 | Acknowledge pin, polarity applied |
| eot_pin_out | output | 1 | End-of-transfer pin value in output mode, polarity applied |
| eot_oe | output | 1 | Output enable for the end-of-transfer pin |
| req_act | output | 1 | Request, corrected to active high |
| eot_req | output | 1 | Incoming end-of-transfer request, corrected to active high |
| done | output | 1 | One-cycle pulse when the access ends |

## Verification
The hardest condition to reach is a second start pulse, together with a new control word, arriving while an access is already in progress. In that case only the length and shape of the pin waveform reveal whether the block has re-latched anything. The driver raises start and rewrites `ctl_word` two cycles into a running access. The scoreboard still expects the original access followed by idle cycles. The terminal-count output is tested under every enabling combination and with both polarities, and the bench compares it with acknowledge cycle by cycle.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACK,
    PH_HOLD,
    PH_DONE
  } phase_e;

  // Field positions inside the channel control word
  localparam int SETUP_LSB = 19;
  localparam int WAIT_LSB  = 13;
  localparam int HOLD_LSB  = 10;
  localparam int EOTDIR_BIT = 9;
  localparam int TCEN_BIT   = 8;

  // Polarity word layout: three bits per channel, packed from the top
  localparam int POL_STRIDE = 3;
  localparam int POL_TOP    = 31;
endpackage

// File: rtl/stb_field_dec.sv
module stb_field_dec
  import stb_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int WAIT_W  = 6,
  parameter int HOLD_W  = 3
) (
  input  logic [31:0]        ctl_word,
  output logic [SETUP_W-1:0] setup_n,
  output logic [WAIT_W-1:0]  wait_n,
  output logic [HOLD_W-1:0]  hold_n,
  output logic               eot_dir,
  output logic               tc_en
);
  always_comb begin
    setup_n = ctl_word[SETUP_LSB +: SETUP_W];
    wait_n  = ctl_word[WAIT_LSB  +: WAIT_W];
    hold_n  = ctl_word[HOLD_LSB  +: HOLD_W];
    eot_dir = ctl_word[EOTDIR_BIT];
    tc_en   = ctl_word[TCEN_BIT];
  end
endmodule

// File: rtl/stb_pol_sel.sv
module stb_pol_sel
  import stb_pkg::*;
#(
  parameter int CH_IDX = 0,
  parameter int N_SIG  = 3
) (
  input  logic [31:0]      pol_word,
  output logic [N_SIG-1:0] pol_bits   // [0]=request, [1]=ack, [2]=end of transfer
);
  localparam int BASE = POL_TOP - POL_STRIDE * CH_IDX;

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    assign pol_bits[g] = pol_word[BASE - g];
  end
endmodule

// File: rtl/stb_phase_seq.sv
module stb_phase_seq
  import stb_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int WAIT_W  = 6,
  parameter int HOLD_W  = 3,
  localparam int CNT_W  = (WAIT_W > SETUP_W) ?
                          ((WAIT_W > HOLD_W) ? WAIT_W : HOLD_W) :
                          ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SETUP_W-1:0] setup_n,
  input  logic [WAIT_W-1:0]  wait_n,
  input  logic [HOLD_W-1:0]  hold_n,
  input  logic               eot_dir,
  input  logic               tc_en,
  input  logic               last_in,
  output phase_e             phase,
  output logic               tc_drive
);
  logic [CNT_W-1:0]  cnt;
  logic [WAIT_W-1:0] wait_q;
  logic [HOLD_W-1:0] hold_q;
  logic              tc_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      wait_q <= '0;
      hold_q <= '0;
      tc_arm <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          wait_q <= wait_n;
          hold_q <= hold_n;
          tc_arm <= eot_dir & tc_en & last_in;
          if (setup_n != '0) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(setup_n) - CNT_W'(1);
          end else begin
            phase <= PH_ACK;
            cnt   <= CNT_W'(wait_n);
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_ACK;
            cnt   <= CNT_W'(wait_q);
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_ACK: begin
          if (cnt == '0) begin
            if (hold_q != '0) begin
              phase <= PH_HOLD;
              cnt   <= CNT_W'(hold_q) - CNT_W'(1);
            end else phase <= PH_DONE;
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_HOLD: begin
          if (cnt == '0) phase <= PH_DONE;
          else cnt <= cnt - CNT_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign tc_drive = tc_arm & (phase == PH_ACK);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DONE |=> phase == PH_IDLE); // R3
  AST_SKIP_SETUP: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start && setup_n == '0) |=> phase == PH_ACK); // R4
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SETUP && start) |=> phase inside {PH_SETUP, PH_ACK}); // R5
  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACK && cnt != '0) |=> phase == PH_ACK); // R2
  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (rst)
    phase == PH_HOLD |=> phase inside {PH_HOLD, PH_DONE}); // R3
endmodule

// File: rtl/stb_timer.sv
module stb_timer
  import stb_pkg::*;
#(
  parameter int CH_IDX  = 0,
  parameter int SETUP_W = 2,
  parameter int WAIT_W  = 6,
  parameter int HOLD_W  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] ctl_word,
  input  logic [31:0] pol_word,
  input  logic        last_xfer,
  input  logic        req_pin,
  input  logic        eot_pin_in,
  output logic        ack_pin,
  output logic        eot_pin_out,
  output logic        eot_oe,
  output logic        req_act,
  output logic        eot_req,
  output logic        done
);
  logic [SETUP_W-1:0] setup_n;
  logic [WAIT_W-1:0]  wait_n;
  logic [HOLD_W-1:0]  hold_n;
  logic               eot_dir, tc_en, tc_drive;
  logic [2:0]         pol;
  phase_e             phase;

  stb_field_dec #(.SETUP_W(SETUP_W), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)) u_dec (
    .ctl_word(ctl_word), .setup_n(setup_n), .wait_n(wait_n), .hold_n(hold_n),
    .eot_dir(eot_dir), .tc_en(tc_en)
  );

  stb_pol_sel #(.CH_IDX(CH_IDX), .N_SIG(3)) u_pol (
    .pol_word(pol_word), .pol_bits(pol)
  );

  stb_phase_seq #(.SETUP_W(SETUP_W), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .setup_n(setup_n), .wait_n(wait_n),
    .hold_n(hold_n), .eot_dir(eot_dir), .tc_en(tc_en), .last_in(last_xfer),
    .phase(phase), .tc_drive(tc_drive)
  );

  // Inputs are corrected first; outputs are inverted last
  assign req_act     = req_pin ^ pol[0];
  assign eot_req     = (eot_pin_in ^ pol[2]) & ~eot_dir;
  assign eot_oe      = eot_dir;
  assign ack_pin     = (phase == PH_ACK) ^ pol[1];
  assign eot_pin_out = tc_drive ^ pol[2];
  assign done        = (phase == PH_DONE);

  AST_EOT_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (rst)
    (eot_pin_out != pol[2]) |-> (ack_pin != pol[1])); // R10
  AST_ACK_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && (ack_pin != pol[1]))); // R2
  AST_EOT_IN_MASKED: assert property (@(posedge clk) disable iff (rst)
    eot_oe |-> !eot_req); // R9
endmodule

// File: tb/sim_stb_timer.sv
module sim_stb_timer;
  localparam int CH = 2;
  localparam int PREQ = 31 - 3*CH, PACK = 30 - 3*CH, PEOT = 29 - 3*CH;

  logic clk = 0, rst = 1, start = 0, last_xfer = 0, req_pin = 0, eot_pin_in = 0;
  logic [31:0] ctl_word = 0, pol_word = 0;
  logic ack_pin, eot_pin_out, eot_oe, req_act, eot_req, done;

  int errors = 0, checks = 0;
  logic [2:0] exp_q[$];   // {ack, done, eot} expected pin values per cycle
  string      tag_q[$];

  always #2.5 clk = ~clk;

  stb_timer #(.CH_IDX(CH)) u0 (
    .clk(clk), .rst(rst), .start(start), .ctl_word(ctl_word), .pol_word(pol_word),
    .last_xfer(last_xfer), .req_pin(req_pin), .eot_pin_in(eot_pin_in),
    .ack_pin(ack_pin), .eot_pin_out(eot_pin_out), .eot_oe(eot_oe),
    .req_act(req_act), .eot_req(eot_req), .done(done)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int s, int w, int h, bit dir, bit en);
    return (32'(s) << 19) | (32'(w) << 13) | (32'(h) << 10) |
           (32'(dir) << 9) | (32'(en) << 8);
  endfunction

  // Monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {29'd0, ack_pin, done, eot_pin_out}, {29'd0, e});
    end
  end

  task automatic push(logic [2:0] v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // Driver: starts an access and queues the expected per-cycle pin values
  task automatic access(int s, int w, int h, bit dir, bit en, bit last,
                        bit disturb, string t);
    logic pa, pe, eo;
    pa = pol_word[PACK];
    pe = pol_word[PEOT];
    eo = dir & en & last;
    ctl_word  = mk(s, w, h, dir, en);
    last_xfer = last;
    start = 1;
    @(posedge clk); #1 start = 0;
    for (int i = 0; i < s; i++)  push({pa, 1'b0, pe}, t);
    for (int i = 0; i <= w; i++) push({~pa, 1'b0, pe ^ eo}, t);
    for (int i = 0; i < h; i++)  push({pa, 1'b0, pe}, t);
    push({pa, 1'b1, pe}, t);
    push({pa, 1'b0, pe}, t);
    push({pa, 1'b0, pe}, t);
    if (disturb) begin
      // R5 R6: restart attempt and field change mid-access
      @(posedge clk); #1;
      ctl_word = mk(0, 9, 0, ~dir, en);
      last_xfer = ~last;
      start = 1;
      @(posedge clk); #1 start = 0;
    end
    while (exp_q.size() > 0) @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk("R1 ack", ack_pin, 0); chk("R1 done", done, 0); chk("R1 eot", eot_pin_out, 0);
    @(posedge clk); #1;
    access(1, 2, 1, 0, 0, 0, 0, "R2 R3 basic");
    access(0, 0, 0, 0, 0, 0, 0, "R4 all zero");
    access(0, 63, 0, 0, 0, 0, 0, "R4 R2 max wait");
    pol_word[PACK] = 1;
    access(3, 5, 7, 0, 0, 0, 0, "R7 active-low ack");
    pol_word[PEOT] = 1;
    access(2, 1, 2, 1, 1, 1, 0, "R10 tc out low");
    pol_word = 0;
    access(2, 1, 2, 1, 1, 1, 0, "R10 tc out high");
    access(1, 3, 1, 1, 0, 1, 0, "R11 tc disabled");
    access(1, 3, 1, 1, 1, 0, 0, "R11 not last");
    access(2, 3, 1, 0, 1, 1, 1, "R5 R6 busy restart");
    access(2, 3, 1, 1, 1, 1, 1, "R6 latched tc");
    // R8 request polarity
    req_pin = 1; #1 chk("R8 high", req_act, 1);
    pol_word[PREQ] = 1; #1 chk("R8 low-active", req_act, 0);
    req_pin = 0; #1 chk("R8 low asserted", req_act, 1);
    pol_word[PREQ+1] = 1; #1 chk("R8 other channel bit ignored", req_act, 1);
    // R9 end-of-transfer input
    ctl_word = mk(0, 0, 0, 0, 0);
    eot_pin_in = 1; #1 chk("R9 in high", eot_req, 1); chk("R10 oe off", eot_oe, 0);
    pol_word[PEOT] = 1; #1 chk("R9 in low-active", eot_req, 0);
    eot_pin_in = 0; #1 chk("R9 in low asserted", eot_req, 1);
    ctl_word = mk(0, 0, 0, 1, 0); #1 chk("R9 masked in output mode", eot_req, 0);
    chk("R10 oe on", eot_oe, 1);
    chk("R11 idle level output", eot_pin_out, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule